// File: doc/BRIEF.md
# Wired Interrupt Aggregator

This block gathers up to thirty-two interrupt sources into one wired request line for a parent interrupt controller. Each source owns one pending bit. Depending on a global sense setting, that bit is set either while the source input is high or when the input rises. A per-source mask decides which pending bits may raise the shared output. When the output is high, software reads the pending register to find the active sources.

Software runs the block over a small register bus. A write of zero clears a pending bit. A separate write-one port lets software re-inject an interrupt on any source. One control bit chooses level or rising-edge sensing for every source at once. A second control bit records that message-based signalling is turned off. That bit is only stored and read back, because the block always drives a wire.

Top module: `irq_fanin_ctrl`

## Requirements
- R1: After reset the pending register reads 0, the mask register reads all ones, the control register reads 0 and `irq_out` is low.
- R2: The registers sit at these byte addresses: pending at 0x00, inject at 0x08, mask at 0x10 and control at 0x28. Read data is registered, so it shows the addressed register one clock after the address is presented. The inject address and all unmapped addresses read as 0.
- R3: Only control bits 3 and 5 are stored. Bit 3 = 1 selects rising-edge sensing and 0 selects level sensing, for all sources together. Every other control bit reads as 0.
- R4: In level mode, a pending bit is set on each clock edge at which its source input is high.
- R5: In edge mode, a pending bit is set only when its source was 0 at the previous edge and is 1 at this edge. A source held high does not set its bit again after the bit is cleared.
- R6: A write to the pending register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R7: A write to the inject register sets every pending bit written as 1.
- R8: If a hardware set and a software clear reach the same pending bit in the same cycle, the bit ends up set.
- R9: A mask bit of 1 blocks its source and a 0 passes it. `irq_out` is registered. It goes high one clock after some pending bit with mask 0 exists, and low one clock after none does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | N_SRC (32) | Write data |
| bus_rdata | output | N_SRC (32) | Registered read data |
| src_in | input | N_SRC (32) | Interrupt source inputs |
| irq_out | output | 1 | Wired interrupt request to the parent |

## Verification
- A source change or register write takes effect at the next clock edge.
- Read data for an address appears one edge after the address is presented.
- `irq_out` reflects the pending and mask state one further edge later.

The bench changes inputs on the falling edge. It waits one falling edge after each source change or write before it reads, and samples `irq_out` both right after a mask write and one falling edge later, which confirms the one-cycle lag. The same-cycle race between a hardware set and a software clear is driven on a single falling edge.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam logic [7:0] OFS_PEND   = 8'h00;
  localparam logic [7:0] OFS_INJECT = 8'h08;
  localparam logic [7:0] OFS_MASK   = 8'h10;
  localparam logic [7:0] OFS_CTRL   = 8'h28;
  localparam int CTL_EDGE_BIT  = 3;
  localparam int CTL_NOMSG_BIT = 5;
endpackage

// File: rtl/irqf_sense.sv
module irqf_sense #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edge_mode,
  input  logic [N_SRC-1:0] src_in,
  output logic [N_SRC-1:0] set_hw
);
  logic [N_SRC-1:0] src_prev;

  always_ff @(posedge clk) begin
    if (rst) src_prev <= '0;
    else     src_prev <= src_in;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_comb begin
      if (edge_mode) set_hw[i] = src_in[i] & ~src_prev[i];
      else           set_hw[i] = src_in[i];
    end
  end
endmodule

// File: rtl/irqf_regfile.sv
module irqf_regfile
  import irqf_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [N_SRC-1:0]  bus_wdata,
  input  logic [N_SRC-1:0]  set_hw,
  output logic [N_SRC-1:0]  cause,
  output logic [N_SRC-1:0]  mask,
  output logic              edge_mode,
  output logic [N_SRC-1:0]  bus_rdata
);
  logic hit_pend, hit_inj, hit_mask, hit_ctrl;
  logic nomsg_q;
  logic [N_SRC-1:0] cause_n;
  logic [N_SRC-1:0] rd_mux;

  assign hit_pend = (bus_addr == ADDR_W'(OFS_PEND));
  assign hit_inj  = (bus_addr == ADDR_W'(OFS_INJECT));
  assign hit_mask = (bus_addr == ADDR_W'(OFS_MASK));
  assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));

  // clear first, then OR in set events so a set beats a clear
  always_comb begin
    cause_n = cause;
    if (bus_we && hit_pend) cause_n = cause_n & bus_wdata;
    if (bus_we && hit_inj)  cause_n = cause_n | bus_wdata;
    cause_n = cause_n | set_hw;
  end

  always_comb begin
    rd_mux = '0;
    if (hit_pend)      rd_mux = cause;
    else if (hit_mask) rd_mux = mask;
    else if (hit_ctrl) begin
      rd_mux[CTL_EDGE_BIT]  = edge_mode;
      rd_mux[CTL_NOMSG_BIT] = nomsg_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause     <= '0;
      mask      <= '1;
      edge_mode <= 1'b0;
      nomsg_q   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      cause     <= cause_n;
      bus_rdata <= rd_mux;
      if (bus_we && hit_mask) mask <= bus_wdata;
      if (bus_we && hit_ctrl) begin
        edge_mode <= bus_wdata[CTL_EDGE_BIT];
        nomsg_q   <= bus_wdata[CTL_NOMSG_BIT];
      end
    end
  end
endmodule

// File: rtl/irq_fanin_ctrl.sv
module irq_fanin_ctrl #(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  input  logic [N_SRC-1:0]  src_in,
  output logic              irq_out
);
  logic [N_SRC-1:0] set_hw;
  logic [N_SRC-1:0] cause;
  logic [N_SRC-1:0] mask;
  logic             edge_mode;

  irqf_sense #(.N_SRC(N_SRC)) u_sense (
    .clk(clk), .rst(rst), .edge_mode(edge_mode),
    .src_in(src_in), .set_hw(set_hw)
  );

  irqf_regfile #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .set_hw(set_hw), .cause(cause),
    .mask(mask), .edge_mode(edge_mode), .bus_rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(cause & ~mask);
  end
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker
  import irqf_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [N_SRC-1:0]  bus_wdata,
  input logic [N_SRC-1:0]  bus_rdata,
  input logic [N_SRC-1:0]  set_hw,
  input logic [N_SRC-1:0]  cause,
  input logic [N_SRC-1:0]  mask,
  input logic              irq_out
);
  a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_out == |($past(cause) & ~$past(mask))));

  a_r8_hw_set_lands: assert property (@(posedge clk) disable iff (rst)
    (set_hw != '0) |=> ((cause & $past(set_hw)) == $past(set_hw)));

  a_r7_inject_lands: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFS_INJECT)) |=>
      ((cause & $past(bus_wdata)) == $past(bus_wdata)));

  a_r6_clear_only_by_write: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == ADDR_W'(OFS_PEND)) |=>
      ((cause & $past(cause)) == $past(cause)));

  a_r2_inject_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(OFS_INJECT)) |=> (bus_rdata == '0));
endmodule

bind irq_fanin_ctrl irqf_checker #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .set_hw(set_hw),
  .cause(cause), .mask(mask), .irq_out(irq_out)
);

// File: tb/test_irq_fanin_ctrl.sv
`timescale 1ns/1ps
module test_irq_fanin_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_in = '0;
  logic        irq_out;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_fanin_ctrl i_irq_fanin_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic drive_src(input logic [31:0] v);
    src_in = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq_out}, 32'h0);
    rd(6'h00, d); chk("R1 pending", d, 32'h0);
    rd(6'h10, d); chk("R1 mask", d, 32'hFFFF_FFFF);
    rd(6'h28, d); chk("R1 control", d, 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(6'h28, 32'hFFFF_FFFF);
    rd(6'h28, d); chk("R3 control bits", d, 32'h0000_0028);
    wr(6'h28, 32'h0000_0020);
    rd(6'h28, d); chk("R3 nomsg only", d, 32'h0000_0020);
    wr(6'h28, 32'h0);
    wr(6'h10, 32'h1234_5678);
    rd(6'h10, d); chk("R2 mask rw", d, 32'h1234_5678);
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h08, d); chk("R2 inject reads 0", d, 32'h0);
    rd(6'h04, d); chk("R2 unmapped 04", d, 32'h0);
    rd(6'h18, d); chk("R2 unmapped 18", d, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(6'h28, 32'h0);
    drive_src(32'h0000_0010);
    rd(6'h00, d); chk("R4 level set", d, 32'h0000_0010);
    wr(6'h00, 32'h0);
    rd(6'h00, d); chk("R8 level held beats clear", d, 32'h0000_0010);
    src_in = 32'h0;
    wr(6'h00, 32'h0);
    rd(6'h00, d); chk("R4 cleared after drop", d, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(6'h28, 32'h0000_0008);
    drive_src(32'h0000_0080);
    rd(6'h00, d); chk("R5 rise sets", d, 32'h0000_0080);
    wr(6'h00, 32'h0);
    rd(6'h00, d); chk("R5 held high no reset", d, 32'h0);
    drive_src(32'h0);
    rd(6'h00, d); chk("R5 fall no set", d, 32'h0);
    drive_src(32'h0000_0080);
    rd(6'h00, d); chk("R5 second rise", d, 32'h0000_0080);
    wr(6'h00, 32'h0);
    drive_src(32'h0);
  endtask

  task automatic t_setwins();
    logic [31:0] d;
    // edge mode still active: rising edge and clear on the same falling edge
    src_in = 32'h0000_0004;
    wr(6'h00, 32'h0);
    rd(6'h00, d); chk("R8 edge beats clear", d, 32'h0000_0004);
    wr(6'h00, 32'h0);
    drive_src(32'h0);
    wr(6'h28, 32'h0);
  endtask

  task automatic t_inject();
    logic [31:0] d;
    wr(6'h08, 32'h8000_0001);
    rd(6'h00, d); chk("R7 inject", d, 32'h8000_0001);
    wr(6'h00, 32'hFFFF_FFFE);
    rd(6'h00, d); chk("R6 zero clears one bit", d, 32'h8000_0000);
    wr(6'h00, 32'h0);
    rd(6'h00, d); chk("R6 clear all", d, 32'h0);
  endtask

  task automatic t_mask();
    wr(6'h08, 32'h0000_0100);
    @(negedge clk);
    chk("R9 masked low", {31'b0, irq_out}, 32'h0);
    wr(6'h10, ~32'h0000_0100);
    chk("R9 lag before rise", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R9 unmasked high", {31'b0, irq_out}, 32'h1);
    wr(6'h10, ~32'h0000_0200);
    chk("R9 lag before fall", {31'b0, irq_out}, 32'h1);
    @(negedge clk);
    chk("R9 other bit masked", {31'b0, irq_out}, 32'h0);
    wr(6'h10, 32'h0);
    wr(6'h00, 32'h0);
    @(negedge clk);
    chk("R9 no pending low", {31'b0, irq_out}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_level();
    t_edge();
    t_setwins();
    t_inject();
    t_mask();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule